// File: doc/BRIEF.md
# Boost Soft-Start and Enable Sequencer

This block decides when a boost regulator may switch and how hard its inductor current may be driven. When enable is high and both the supply and temperature flags are clear, switching turns on. The current-limit code starts on its lowest step and climbs one step at a time to its final value. A downstream analog limiter converts the code at 225 mA per step, so step 8 gives the full 1.8 A. Steps are timed by a 1 ms tick. When the LED dimming duty is low, each step lasts two ticks instead of one, which stretches the ramp.

A brief drop of enable does not disturb a running regulator. Enable must stay low for 28 consecutive ticks before the block shuts down. An undervoltage event stops switching at once and locks the block. It stays off until the supply is good again and enable has been taken low and brought high again. An over-temperature event also stops switching. Every restart from the off state replays the soft-start staircase from step 1.

Top module: `boost_sst_seq`

## Requirements
- R1: One cycle after a clock edge that samples `en_in` high with `uv_flag` and `ot_flag` low while the block is off, `sw_en` is 1 and `ilim_code` is 1. Code value n means a limit of n × 225 mA, as a 4-bit unsigned number.
- R2: While switching, `ilim_code` only ever rises by exactly one. It stops at 8 and holds 8 from then on.
- R3: With `low_duty` low, the code advances on every sampled `tick_ms` and reaches 8 on the seventh tick after start. With `low_duty` high, each advance needs two sampled ticks.
- R4: If `en_in` is low for fewer than 28 consecutive sampled ticks, switching continues and `ilim_code` keeps its value.
- R5: On the 28th consecutive sampled tick with `en_in` low, `sw_en` and `ilim_code` drop to 0 on the following cycle.
- R6: A sampled `uv_flag` gives `sw_en` = 0 and `ilim_code` = 0 on the next cycle.
- R7: After an undervoltage event, the block stays off even when `uv_flag` clears with `en_in` high. A restart needs a cycle with `en_in` low and `uv_flag` clear, then `en_in` high again. The restart begins at code 1.
- R8: A sampled `ot_flag` gives `sw_en` = 0 on the next cycle. Once `ot_flag` clears with `en_in` high, soft-start begins again at code 1.
- R9: After synchronous reset, `sw_en` is 0 and `ilim_code` is 0.
- R10: `ilim_code` is 0 whenever `sw_en` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_in | input | 1 | Enable request |
| uv_flag | input | 1 | Input undervoltage detected |
| ot_flag | input | 1 | Over-temperature detected |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| low_duty | input | 1 | Dimming duty is low; stretch each step |
| sw_en | output | 1 | Boost switching allowed |
| ilim_code | output | 4 | Current-limit step code, 225 mA per step |

## Verification
Every output is a function of registered state only. Any input sampled at one rising edge shows its effect on `sw_en` and `ilim_code` just after that same edge, with one cycle of latency. Fault responses, the start step and each staircase advance therefore appear exactly one cycle after the edge that samples the cause. The bench drives inputs just after a rising edge and compares against its own cycle model 2 ns after the next edge. The off-timeout appears one cycle after the 28th low-enable tick, and the directed checks count ticks exactly to that edge.

// File: rtl/sst_pkg.sv
package sst_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_SOFT  = 2'd1,
        ST_RUN   = 2'd2,
        ST_FAULT = 2'd3
    } sst_state_e;

    localparam int CODE_W    = 4;
    localparam int STEPS     = 8;
    localparam int OFF_TICKS = 28;
    localparam int FAST_DIV  = 1;
    localparam int SLOW_DIV  = 2;

    function automatic int step_period(input logic slow, input int fast_div, input int slow_div);
        return slow ? slow_div : fast_div;
    endfunction

endpackage

// File: rtl/sst_off_timer.sv
module sst_off_timer #(
    parameter int OFF_TICKS = 28,
    localparam int CW = $clog2(OFF_TICKS + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic en_in,
    input  logic tick_ms,
    output logic expire
);
    logic [CW-1:0] cnt_q;

    assign expire = active && !en_in && tick_ms && (cnt_q == CW'(OFF_TICKS - 1));

    always_ff @(posedge clk) begin
        if (rst || !active || en_in || expire) begin
            cnt_q <= '0;
        end else if (tick_ms) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_OFF_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q < CW'(OFF_TICKS)); // R5

    AST_EN_HIGH_CLEARS: assert property (@(posedge clk) disable iff (rst)
        en_in |=> (cnt_q == '0)); // R4

endmodule

// File: rtl/sst_staircase.sv
module sst_staircase
    import sst_pkg::*;
#(
    parameter int CODE_W   = 4,
    parameter int STEPS    = 8,
    parameter int FAST_DIV = 1,
    parameter int SLOW_DIV = 2,
    localparam int TW = $clog2(SLOW_DIV + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              active,
    input  logic              tick_ms,
    input  logic              low_duty,
    output logic [CODE_W-1:0] code,
    output logic              done
);
    logic [TW-1:0]     tcnt_q;
    logic [CODE_W-1:0] code_q;
    logic [TW:0]       tcnt_inc;
    logic [TW:0]       period;
    logic              advance;

    assign tcnt_inc = {1'b0, tcnt_q} + 1'b1;
    assign period   = (TW+1)'(step_period(low_duty, FAST_DIV, SLOW_DIV));
    assign advance  = active && tick_ms && (tcnt_inc >= period);
    assign done     = advance && (code_q == CODE_W'(STEPS - 1));
    assign code     = code_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0;
            tcnt_q <= '0;
        end else if (load) begin
            code_q <= CODE_W'(1);
            tcnt_q <= '0;
        end else if (active && tick_ms) begin
            if (advance) begin
                tcnt_q <= '0;
                code_q <= code_q + 1'b1;
            end else begin
                tcnt_q <= tcnt_inc[TW-1:0];
            end
        end
    end

    AST_NO_STEP_WITHOUT_TICK: assert property (@(posedge clk) disable iff (rst)
        (!tick_ms && !load) |=> $stable(code_q)); // R3

    AST_TCNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        {1'b0, tcnt_q} < (TW+1)'(SLOW_DIV)); // R3

endmodule

// File: rtl/boost_sst_seq.sv
module boost_sst_seq
    import sst_pkg::*;
#(
    parameter int STEP_COUNT = sst_pkg::STEPS,
    parameter int OFF_LIMIT  = sst_pkg::OFF_TICKS,
    parameter int FAST_TICKS = sst_pkg::FAST_DIV,
    parameter int SLOW_TICKS = sst_pkg::SLOW_DIV
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      en_in,
    input  logic                      uv_flag,
    input  logic                      ot_flag,
    input  logic                      tick_ms,
    input  logic                      low_duty,
    output logic                      sw_en,
    output logic [sst_pkg::CODE_W-1:0] ilim_code
);
    sst_state_e        state_q, state_d;
    logic              start;
    logic              ramping;
    logic              switching;
    logic              expire;
    logic              stair_done;
    logic [CODE_W-1:0] stair_code;

    assign start     = (state_q == ST_OFF) && en_in && !uv_flag && !ot_flag;
    assign ramping   = (state_q == ST_SOFT);
    assign switching = (state_q == ST_SOFT) || (state_q == ST_RUN);

    sst_off_timer #(.OFF_TICKS(OFF_LIMIT)) u_off (
        .clk     (clk),
        .rst     (rst),
        .active  (switching),
        .en_in   (en_in),
        .tick_ms (tick_ms),
        .expire  (expire)
    );

    sst_staircase #(
        .CODE_W   (CODE_W),
        .STEPS    (STEP_COUNT),
        .FAST_DIV (FAST_TICKS),
        .SLOW_DIV (SLOW_TICKS)
    ) u_stair (
        .clk      (clk),
        .rst      (rst),
        .load     (start),
        .active   (ramping),
        .tick_ms  (tick_ms),
        .low_duty (low_duty),
        .code     (stair_code),
        .done     (stair_done)
    );

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_OFF: begin
                if (uv_flag)    state_d = ST_FAULT;
                else if (start) state_d = ST_SOFT;
            end
            ST_SOFT, ST_RUN: begin
                if (uv_flag)                             state_d = ST_FAULT;
                else if (ot_flag || expire)              state_d = ST_OFF;
                else if (state_q == ST_SOFT && stair_done) state_d = ST_RUN;
            end
            ST_FAULT: begin
                if (!uv_flag && !en_in) state_d = ST_OFF;
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_OFF;
        else     state_q <= state_d;
    end

    assign sw_en     = switching;
    assign ilim_code = switching ? stair_code : '0;

    AST_START_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        $rose(sw_en) |-> (ilim_code == CODE_W'(1))); // R1

    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (rst)
        (sw_en && $past(sw_en) && (ilim_code != $past(ilim_code)))
            |-> (ilim_code == $past(ilim_code) + 1'b1)); // R2

    AST_CODE_CEILING: assert property (@(posedge clk) disable iff (rst)
        ilim_code <= CODE_W'(STEP_COUNT)); // R2

    AST_UV_STOPS: assert property (@(posedge clk) disable iff (rst)
        uv_flag |=> !sw_en); // R6

    AST_UV_LOCK: assert property (@(posedge clk) disable iff (rst)
        ($past(uv_flag) && !sw_en && en_in) |=> !sw_en); // R7

    AST_OT_STOPS: assert property (@(posedge clk) disable iff (rst)
        ot_flag |=> !sw_en); // R8

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !sw_en |-> (ilim_code == '0)); // R10

endmodule

// File: tb/sim_boost_sst_seq.sv
module sim_boost_sst_seq;
    logic       clk = 1'b0;
    logic       rst;
    logic       en_in, uv_flag, ot_flag, tick_ms, low_duty;
    logic       sw_en;
    logic [3:0] ilim_code;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    // bench model: 0 off, 1 soft-start, 2 run, 3 fault
    int m_st, m_code, m_t, m_o;

    always #10 clk = ~clk;

    boost_sst_seq u0 (
        .clk(clk), .rst(rst), .en_in(en_in), .uv_flag(uv_flag), .ot_flag(ot_flag),
        .tick_ms(tick_ms), .low_duty(low_duty), .sw_en(sw_en), .ilim_code(ilim_code)
    );

    function automatic int exp_sw();
        return (m_st == 1 || m_st == 2) ? 1 : 0;
    endfunction

    function automatic int exp_code();
        return exp_sw() ? m_code : 0;
    endfunction

    task automatic model_step(input bit en, input bit uv, input bit ot, input bit tk, input bit ld);
        int per;
        case (m_st)
            0: begin
                m_o = 0;
                if (uv) m_st = 3;
                else if (en && !ot) begin m_st = 1; m_code = 1; m_t = 0; end
            end
            1, 2: begin
                if (uv) begin m_st = 3; m_o = 0; end
                else if (ot) begin m_st = 0; m_o = 0; end
                else if (!en && tk && m_o == 27) begin m_st = 0; m_o = 0; end
                else begin
                    if (en) m_o = 0; else if (tk) m_o = m_o + 1;
                    if (m_st == 1 && tk) begin
                        per = ld ? 2 : 1;
                        if (m_t + 1 >= per) begin
                            m_t = 0; m_code = m_code + 1;
                            if (m_code == 8) m_st = 2;
                        end else m_t = m_t + 1;
                    end
                end
            end
            default: if (!uv && !en) m_st = 0;
        endcase
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input bit en, input bit uv, input bit ot, input bit tk, input bit ld, input string req);
        en_in = en; uv_flag = uv; ot_flag = ot; tick_ms = tk; low_duty = ld;
        @(posedge clk);
        model_step(en, uv, ot, tk, ld);
        #2;
        chk(int'(sw_en) == exp_sw(), {req, " sw_en"}, int'(sw_en), exp_sw());
        chk(int'(ilim_code) == exp_code(), {req, " code"}, int'(ilim_code), exp_code());
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        m_st = 0; m_code = 0; m_t = 0; m_o = 0;
        rst = 1; en_in = 0; uv_flag = 0; ot_flag = 0; tick_ms = 0; low_duty = 0;
        repeat (3) @(posedge clk);
        #2;
        chk(sw_en == 1'b0 && ilim_code == 4'd0, "R9 reset", int'(ilim_code), 0);
        rst = 0;

        // R1 start at step 1
        cyc(1, 0, 0, 0, 0, "R1");
        chk(ilim_code == 4'd1, "R1 first step", int'(ilim_code), 1);
        // R3 no advance without tick, then one step per tick
        cyc(1, 0, 0, 0, 0, "R3 idle");
        for (int i = 2; i <= 8; i++) begin
            cyc(1, 0, 0, 1, 0, "R2 step");
            chk(ilim_code == 4'(i), "R3 fast step", int'(ilim_code), i);
        end
        cyc(1, 0, 0, 1, 0, "R2 hold");
        chk(ilim_code == 4'd8, "R2 ceiling", int'(ilim_code), 8);

        // R4 enable low for 27 ticks keeps running
        for (int i = 0; i < 27; i++) cyc(0, 0, 0, 1, 0, "R4");
        chk(sw_en == 1'b1 && ilim_code == 4'd8, "R4 short low", int'(ilim_code), 8);
        cyc(1, 0, 0, 1, 0, "R4 back");
        // R5 28 ticks low shuts down
        for (int i = 0; i < 27; i++) cyc(0, 0, 0, 1, 0, "R5 low");
        cyc(0, 0, 0, 0, 0, "R5 gap");
        cyc(0, 0, 0, 1, 0, "R5 last");
        chk(sw_en == 1'b0 && ilim_code == 4'd0, "R5 shutdown", int'(sw_en), 0);

        // R3 low duty: two ticks per step
        cyc(1, 0, 0, 0, 1, "R1 restart");
        chk(ilim_code == 4'd1, "R1 restart step", int'(ilim_code), 1);
        cyc(1, 0, 0, 1, 1, "R3 slow a");
        chk(ilim_code == 4'd1, "R3 slow hold", int'(ilim_code), 1);
        cyc(1, 0, 0, 1, 1, "R3 slow b");
        chk(ilim_code == 4'd2, "R3 slow step", int'(ilim_code), 2);

        // R6 undervoltage
        cyc(1, 1, 0, 0, 0, "R6");
        chk(sw_en == 1'b0 && ilim_code == 4'd0, "R6 uv stop", int'(sw_en), 0);
        // R7 lock while enable held high
        for (int i = 0; i < 5; i++) cyc(1, 0, 0, 1, 0, "R7 lock");
        chk(sw_en == 1'b0, "R7 still off", int'(sw_en), 0);
        cyc(0, 0, 0, 0, 0, "R7 drop");
        cyc(1, 0, 0, 0, 0, "R7 re-enable");
        chk(sw_en == 1'b1 && ilim_code == 4'd1, "R7 restart", int'(ilim_code), 1);

        // R8 over-temperature
        cyc(1, 0, 0, 1, 0, "R8 pre");
        cyc(1, 0, 1, 0, 0, "R8");
        chk(sw_en == 1'b0, "R8 ot stop", int'(sw_en), 0);
        cyc(1, 0, 1, 0, 0, "R8 held");
        cyc(1, 0, 0, 0, 0, "R8 clear");
        chk(sw_en == 1'b1 && ilim_code == 4'd1, "R8 restart", int'(ilim_code), 1);

        // random phase against model
        for (int i = 0; i < 4000; i++) begin
            cyc(($urandom % 16) != 0, ($urandom % 120) == 0, ($urandom % 100) == 0,
                ($urandom % 3) == 0, ($urandom % 8) < 3, "R10 model");
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule